// File: doc/BRIEF.md
# Vertical Text-Line Sequencer for an On-Screen Display

This block tracks where the raster is vertically and tells a character pipeline what to draw on each scan line. It counts scan lines from every active vertical sync edge and marks each one either as a blank line or as one font row of a given text line. The character pipeline uses the row flag, the font-row index and the text-line index to fetch glyph data. Each text line has its own character size, which makes every font row take 1 to 4 scan lines. A global spacing setting inserts blank scan lines between text lines.

The sequencer is a five-state machine.
- `ST_IDLE`: the state after reset, held until the first vertical edge.
- `ST_LEAD`: the blank lines before the first text line.
- `ST_GLYPH`: the visible font rows.
- `ST_GAP`: the inter-line spacing.
- `ST_DONE`: entered once the last text line has been used.

Transitions:
- Any state goes to `ST_LEAD` on a vertical edge.
- `ST_LEAD` goes to `ST_GLYPH` when the start count is met.
- `ST_GLYPH` goes to `ST_GAP` after the last row, when spacing is non-zero.
- `ST_GLYPH` or `ST_GAP` goes back to `ST_GLYPH` to start the next text line.
- `ST_GLYPH` or `ST_GAP` goes to `ST_DONE` after text line 15.

The size of each text line is requested through a one-cycle pulse. The value on the size input is sampled on the horizontal edge that starts that text line.

Top module: `osd_vline_seq`

## Requirements
- R1: After reset the outputs are `row_active`=0, `font_row`=0, `text_line`=0 and `size_req`=0. Horizontal edges seen before the first active vertical edge leave them unchanged.
- R2: With a polarity bit at 1, the rising edge of that sync input is active. With the bit at 0, the falling edge is active. Transitions in the other direction do nothing.
- R3: An active vertical edge drops `row_active`, clears `text_line` to 0 and produces one `size_req` pulse, which asks for the size of text line 0.
- R4: The first horizontal edge after a vertical edge starts scan line 0. Row 1 of text line 0 starts on scan line `v_start`×4. All earlier scan lines are blank.
- R5: While `row_active` is 1, `font_row` steps through 1 to 18 in order. It is never 0 while the row is active, and it reads 0 while the row is inactive.
- R6: Size code c (0..3) makes every font row of the text line last c+1 scan lines. The code is sampled only on the horizontal edge that starts the text line.
- R7: Spacing select s (0..3) inserts 4×s blank scan lines after row 18 of every text line. `text_line` keeps its value during these lines.
- R8: `size_req` pulses for one clock right after the horizontal edge that starts the last scan line of a text line's block, counting its spacing lines. There is no pulse for text line 15.
- R9: `text_line` goes up by one for each new text line. After the block of text line 15 ends, `row_active` stays 0 and `text_line` stays 15 until the next vertical edge.
- R10: When a vertical edge and a horizontal edge arrive in the same cycle, the vertical edge wins and the horizontal edge is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| hs_act_high | input | 1 | 1: rising edge of hsync_in is active; 0: falling edge |
| vs_act_high | input | 1 | 1: rising edge of vsync_in is active; 0: falling edge |
| v_start | input | 6 | Start offset, in units of 4 scan lines |
| gap_sel | input | 2 | Spacing select, gives 4×value blank lines |
| size_code | input | 2 | Size of the text line about to start (repeats = code+1) |
| row_active | output | 1 | Current scan line shows a font row |
| font_row | output | 5 | Font row 1..18, or 0 when inactive |
| text_line | output | 4 | Index of the current text line |
| size_req | output | 1 | One-cycle request for the next text line's size |

## Verification
The bench runs four frame patterns.
- Active-high syncs, no start offset, no spacing, and a size that changes on every text line. This separates per-line size handling from a shared size, and shows that the size input is sampled only at a line's first edge.
- Active-low syncs with a non-zero offset and spacing, cut short by a new vertical edge. This separates edge polarity, the lead count and the gap count, and shows how a frame restart recovers.
- Simultaneous vertical and horizontal edges. This shows the priority rule.
- A full frame with single spacing and a fixed size. This exercises the `ST_DONE` hold.

A running count of request pulses is compared at every scan line, so a missing or extra request is caught at the line where it happens.

// File: rtl/osdv_pkg.sv
package osdv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_GLYPH,
        ST_GAP,
        ST_DONE
    } vseq_state_e;

endpackage

// File: rtl/osdv_sync_edge.sv
module osdv_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic act_high,
    output logic edge_o
);

    logic lvl;
    logic prev_q;

    assign lvl = act_high ? sync_in : ~sync_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl;
        end
    end

    assign edge_o = lvl & ~prev_q;

endmodule

// File: rtl/osdv_line_fsm.sv
module osdv_line_fsm
    import osdv_pkg::*;
#(
    parameter int ROWS       = 18,
    parameter int MAX_LINES  = 16,
    parameter int START_W    = 6,
    parameter int START_UNIT = 4,
    parameter int GAP_W      = 2,
    parameter int GAP_UNIT   = 4,
    parameter int SIZE_W     = 2,
    parameter int ROW_W      = $clog2(ROWS + 1),
    parameter int LINE_W     = $clog2(MAX_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_edge,
    input  logic              vs_edge,
    input  logic [START_W-1:0] v_start,
    input  logic [GAP_W-1:0]  gap_sel,
    input  logic [SIZE_W-1:0] size_code,
    output logic              row_active,
    output logic [ROW_W-1:0]  font_row,
    output logic [LINE_W-1:0] text_line,
    output logic              size_req
);

    localparam int CNT_W_LEAD = START_W + $clog2(START_UNIT) + 1;
    localparam int CNT_W_GAP  = GAP_W + $clog2(GAP_UNIT) + 1;
    localparam int CNT_W      = (CNT_W_LEAD > CNT_W_GAP) ? CNT_W_LEAD : CNT_W_GAP;
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(MAX_LINES - 1);

    vseq_state_e       st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ROW_W-1:0]  row_q, row_d;
    logic [SIZE_W-1:0] rep_q, rep_d;
    logic [SIZE_W-1:0] size_q, size_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic              req_q, req_d;

    logic [CNT_W-1:0]  lead_lines;
    logic [CNT_W-1:0]  gap_lines;
    logic              advance;

    assign lead_lines = CNT_W'(v_start * START_UNIT);
    assign gap_lines  = CNT_W'(gap_sel * GAP_UNIT);

    // next-state logic
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        row_d   = row_q;
        rep_d   = rep_q;
        size_d  = size_q;
        line_d  = line_q;
        req_d   = 1'b0;
        advance = 1'b0;
        if (vs_edge) begin
            st_d   = ST_LEAD;
            cnt_d  = '0;
            row_d  = '0;
            rep_d  = '0;
            line_d = '0;
            req_d  = 1'b1;
        end else if (hs_edge) begin
            unique case (st_q)
                ST_IDLE: begin
                end
                ST_LEAD: begin
                    if (cnt_q == lead_lines) begin
                        st_d   = ST_GLYPH;
                        row_d  = ROW_W'(1);
                        rep_d  = '0;
                        size_d = size_code;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_GLYPH: begin
                    if (rep_q != size_q) begin
                        rep_d = rep_q + 1'b1;
                    end else if (row_q != LAST_ROW) begin
                        row_d = row_q + 1'b1;
                        rep_d = '0;
                    end else if (gap_lines != '0) begin
                        st_d  = ST_GAP;
                        cnt_d = '0;
                    end else begin
                        advance = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (CNT_W'(cnt_q + 1'b1) != gap_lines) begin
                        cnt_d = cnt_q + 1'b1;
                    end else begin
                        advance = 1'b1;
                    end
                end
                ST_DONE: begin
                end
            endcase
            if (advance) begin
                if (line_q == LAST_LINE) begin
                    st_d = ST_DONE;
                end else begin
                    st_d   = ST_GLYPH;
                    line_d = line_q + 1'b1;
                    row_d  = ROW_W'(1);
                    rep_d  = '0;
                    size_d = size_code;
                end
            end
            // look ahead: does the scan line just started close the block?
            if (line_d != LAST_LINE) begin
                if (st_d == ST_GLYPH && row_d == LAST_ROW && rep_d == size_d && gap_lines == '0) begin
                    req_d = 1'b1;
                end
                if (st_d == ST_GAP && CNT_W'(cnt_d + 1'b1) == gap_lines) begin
                    req_d = 1'b1;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            row_q  <= '0;
            rep_q  <= '0;
            size_q <= '0;
            line_q <= '0;
            req_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            row_q  <= row_d;
            rep_q  <= rep_d;
            size_q <= size_d;
            line_q <= line_d;
            req_q  <= req_d;
        end
    end

    // outputs
    always_comb begin
        row_active = 1'b0;
        font_row   = '0;
        unique case (st_q)
            ST_GLYPH: begin
                row_active = 1'b1;
                font_row   = row_q;
            end
            ST_IDLE, ST_LEAD, ST_GAP, ST_DONE: begin
            end
        endcase
        text_line = line_q;
        size_req  = req_q;
    end

endmodule

// File: rtl/osd_vline_seq.sv
module osd_vline_seq #(
    parameter int ROWS       = 18,
    parameter int MAX_LINES  = 16,
    parameter int START_W    = 6,
    parameter int START_UNIT = 4,
    parameter int GAP_W      = 2,
    parameter int GAP_UNIT   = 4,
    parameter int SIZE_W     = 2,
    parameter int ROW_W      = $clog2(ROWS + 1),
    parameter int LINE_W     = $clog2(MAX_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              hs_act_high,
    input  logic              vs_act_high,
    input  logic [START_W-1:0] v_start,
    input  logic [GAP_W-1:0]  gap_sel,
    input  logic [SIZE_W-1:0] size_code,
    output logic              row_active,
    output logic [ROW_W-1:0]  font_row,
    output logic [LINE_W-1:0] text_line,
    output logic              size_req
);

    localparam int N_SYNC = 2;

    logic [N_SYNC-1:0] sync_raw;
    logic [N_SYNC-1:0] sync_pol;
    logic [N_SYNC-1:0] sync_edge;

    assign sync_raw = {vsync_in, hsync_in};
    assign sync_pol = {vs_act_high, hs_act_high};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        osdv_sync_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (sync_raw[g]),
            .act_high (sync_pol[g]),
            .edge_o   (sync_edge[g])
        );
    end

    osdv_line_fsm #(
        .ROWS       (ROWS),
        .MAX_LINES  (MAX_LINES),
        .START_W    (START_W),
        .START_UNIT (START_UNIT),
        .GAP_W      (GAP_W),
        .GAP_UNIT   (GAP_UNIT),
        .SIZE_W     (SIZE_W),
        .ROW_W      (ROW_W),
        .LINE_W     (LINE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_edge    (sync_edge[0]),
        .vs_edge    (sync_edge[1]),
        .v_start    (v_start),
        .gap_sel    (gap_sel),
        .size_code  (size_code),
        .row_active (row_active),
        .font_row   (font_row),
        .text_line  (text_line),
        .size_req   (size_req)
    );

endmodule

// File: rtl/osdv_vseq_chk.sv
module osdv_vseq_chk #(
    parameter int ROWS   = 18,
    parameter int ROW_W  = 5,
    parameter int LINE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vsync_in,
    input logic              vs_act_high,
    input logic              row_active,
    input logic [ROW_W-1:0]  font_row,
    input logic [LINE_W-1:0] text_line,
    input logic              size_req
);

    logic vs_lvl_c;
    logic vs_prev_c;
    logic vs_hit_c;

    assign vs_lvl_c = vs_act_high ? vsync_in : ~vsync_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_prev_c <= 1'b0;
        end else begin
            vs_prev_c <= vs_lvl_c;
        end
    end

    assign vs_hit_c = vs_lvl_c & ~vs_prev_c;

    // R5
    active_row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_active |-> (font_row >= ROW_W'(1) && font_row <= ROW_W'(ROWS)));

    // R5
    idle_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !row_active |-> (font_row == '0));

    // R5
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_active && $past(row_active) && font_row != $past(font_row))
        |-> (font_row == ROW_W'($past(font_row) + 1'b1) || font_row == ROW_W'(1)));

    // R3
    vsync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_hit_c |=> (text_line == '0 && !row_active && size_req));

    // R8
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_req |=> !size_req);

    // R9
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (text_line != $past(text_line))
        |-> (text_line == LINE_W'($past(text_line) + 1'b1) || text_line == '0));

endmodule

bind osd_vline_seq osdv_vseq_chk #(
    .ROWS   (ROWS),
    .ROW_W  (ROW_W),
    .LINE_W (LINE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_in    (vsync_in),
    .vs_act_high (vs_act_high),
    .row_active  (row_active),
    .font_row    (font_row),
    .text_line   (text_line),
    .size_req    (size_req)
);

// File: tb/osd_vline_seq_tb_top.sv
`timescale 1ns/1ps
module osd_vline_seq_tb_top;

    typedef struct {
        bit    act;
        int    row;
        int    line;
        int    reqs;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic       vsync_in = 1'b0;
    logic       hs_act_high = 1'b1;
    logic       vs_act_high = 1'b1;
    logic [5:0] v_start = '0;
    logic [1:0] gap_sel = '0;
    logic [1:0] size_code = '0;
    logic       row_active;
    logic [4:0] font_row;
    logic [3:0] text_line;
    logic       size_req;

    exp_t q[$];
    event sample_ev;
    int   n_chk = 0;
    int   n_fail = 0;
    int   exp_reqs = 0;
    int   seen_reqs = 0;
    bit   done = 0;
    int   size_tab[16];

    always #4 clk = ~clk;

    osd_vline_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync_in    (hsync_in),
        .vsync_in    (vsync_in),
        .hs_act_high (hs_act_high),
        .vs_act_high (vs_act_high),
        .v_start     (v_start),
        .gap_sel     (gap_sel),
        .size_code   (size_code),
        .row_active  (row_active),
        .font_row    (font_row),
        .text_line   (text_line),
        .size_req    (size_req)
    );

    always @(posedge clk) begin
        if (size_req) seen_reqs <= seen_reqs + 1;
    end

    // monitor: pops one expected item per sampled scan line
    initial begin
        forever begin
            @(sample_ev);
            n_chk++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: actual=sample expected=item");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (row_active !== e.act || int'(font_row) != e.row ||
                    int'(text_line) != e.line || seen_reqs != e.reqs) begin
                    n_fail++;
                    $display("FAIL %s: actual act=%0b row=%0d line=%0d reqs=%0d expected act=%0b row=%0d line=%0d reqs=%0d",
                             e.tag, row_active, font_row, text_line, seen_reqs,
                             e.act, e.row, e.line, e.reqs);
                end
            end
        end
    end

    task automatic settle_and_sample();
        repeat (2) @(negedge clk);
        ->sample_ev;
    endtask

    task automatic hline(input logic [1:0] sz, input bit a, input int r, input int l,
                         input string tag, input bit rq);
        size_code = sz;
        if (rq) exp_reqs++;
        q.push_back('{act: a, row: r, line: l, reqs: exp_reqs, tag: tag});
        @(negedge clk) hsync_in = hs_act_high;
        repeat (2) @(negedge clk);
        hsync_in = ~hs_act_high;
        settle_and_sample();
    endtask

    task automatic vpulse(input bit with_h, input string tag);
        exp_reqs++;
        q.push_back('{act: 1'b0, row: 0, line: 0, reqs: exp_reqs, tag: tag});
        @(negedge clk);
        vsync_in = vs_act_high;
        if (with_h) hsync_in = hs_act_high;
        repeat (2) @(negedge clk);
        vsync_in = ~vs_act_high;
        hsync_in = ~hs_act_high;
        settle_and_sample();
    endtask

    task automatic set_pol(input bit p);
        @(negedge clk);
        hs_act_high = p;
        vs_act_high = p;
        hsync_in = ~p;
        vsync_in = ~p;
    endtask

    task automatic run_frame(input bit do_vs, input int vst, input int spc, input int nl);
        v_start = 6'(vst);
        gap_sel = 2'(spc);
        if (do_vs) vpulse(1'b0, "R3");
        // R4 lead lines (R2 when syncs are active-low)
        for (int s = 0; s < vst * 4; s++)
            hline(2'(size_tab[0]), 1'b0, 0, 0, hs_act_high ? "R4" : "R2", 1'b0);
        for (int l = 0; l < nl; l++) begin
            for (int r = 1; r <= 18; r++) begin
                for (int k = 0; k <= size_tab[l]; k++) begin
                    bit first, last;
                    first = (r == 1 && k == 0);
                    last  = (r == 18 && k == size_tab[l] && spc == 0 && l < 15);
                    hline(first ? 2'(size_tab[l]) : 2'(size_tab[(l + 1) % 16]), 1'b1, r, l,
                          last ? "R8" : (k > 0 ? "R6" : "R5"), last);
                end
            end
            for (int g = 0; g < spc * 4; g++) begin
                bit last;
                last = (g == spc * 4 - 1 && l < 15);
                hline(2'(size_tab[(l + 1) % 16]), 1'b0, 0, l, last ? "R8" : "R7", last);
            end
        end
        if (nl == 16) begin
            for (int e = 0; e < 4; e++)
                hline(2'(e), 1'b0, 0, 15, "R9", 1'b0);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        q.push_back('{act: 1'b0, row: 0, line: 0, reqs: 0, tag: "R1"});
        settle_and_sample();
        // R1 horizontal edge before any vertical edge does nothing
        hline(2'd3, 1'b0, 0, 0, "R1", 1'b0);

        // frame 1: sizes vary per line, no offset, no spacing
        for (int i = 0; i < 16; i++) size_tab[i] = i % 4;
        run_frame(1'b1, 0, 0, 16);

        // frame 2: active-low syncs, offset and spacing, cut short
        set_pol(1'b0);
        for (int i = 0; i < 16; i++) size_tab[i] = 3 - (i % 4);
        run_frame(1'b1, 3, 2, 3);

        // frame 3: R10 simultaneous vertical and horizontal edges
        set_pol(1'b1);
        for (int i = 0; i < 16; i++) size_tab[i] = (i + 1) % 4;
        vpulse(1'b1, "R10");
        run_frame(1'b0, 0, 3, 2);

        // frame 4: full frame, offset 1, single spacing, fixed size
        for (int i = 0; i < 16; i++) size_tab[i] = 1;
        run_frame(1'b1, 1, 1, 16);

        repeat (4) @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule